// File: doc/BRIEF.md
# Power-Amplifier Drain Enable Controller

This block produces the digital enable that drives an external switch gating drain current into a power-amplifier transistor. Software turns the switch on through a small register port. A set of fault inputs from on-chip monitors can shut the switch off automatically: thermal, positive supply, negative supply, converter and reference. Each fault source has its own select bit, and only selected faults can force a shutdown. A shutdown is latched. The enable bit is cleared internally, so software has to enable the output again once the fault has gone away.

The logical ON/OFF state is mapped onto the pad through two configuration bits. The first inverts polarity. The second chooses between push-pull drive and open-drain drive. In open-drain mode the block only pulls the pad low, and it releases the pad (output-enable low) when the level should be high. Fault inputs are taken to be asynchronous to the block clock and pass through a two-flop synchronizer before masking.

Register map (3-bit address, 8-bit data, single-cycle writes, combinational reads). Address 0 is control, with bit 0 as the enable. Address 1 is status, with bit 0 giving the ON state (read-only). Address 2 is source select A, with bits 2:0 selecting faults 0 to 2. Address 3 is source select B, with bits 1:0 selecting faults 3 to 4. Address 4 is pad configuration, with bit 0 for inverted polarity and bit 1 for open-drain. The fault vector is indexed as follows: 0 thermal, 1 positive supply, 2 negative supply, 3 converter, 4 reference.

Top module: `pa_drain_ctl`

## Requirements
- R1: After reset the enable and status bits read 0, the output is OFF, and with default configuration `pad_out`=0 and `pad_oe`=1.
- R2: Writing 1 to bit 0 of address 0 turns the output ON at the following clock edge, as long as no selected fault is active. Writing 0 turns it OFF.
- R3: Bit 0 of address 1 (status) and bit 0 of address 0 (control readback) both show the current ON state.
- R4: Address 2 bits 2:0 select faults 0 to 2, and address 3 bits 1:0 select faults 3 to 4. An active selected fault forces the output OFF at the third rising edge after the raw input rises (two synchronizer stages, then one state update).
- R5: Faults whose select bit is clear have no effect on the ON state or on the pad.
- R6: A fault shutdown is sticky. The output stays OFF after the fault clears until enable is written again. A write of 1 while a selected fault is active is ignored.
- R7: Bit 0 of address 4 inverts polarity. When clear, ON drives the high level. When set, ON drives the low level.
- R8: Bit 1 of address 4 selects open-drain drive. In that mode `pad_out`=0, and `pad_oe` is 1 only when the mapped level is low. In push-pull mode `pad_oe`=1 and `pad_out` equals the mapped level.
- R9: Writing the configuration register changes the pad mapping at the next edge and never changes the ON state or the status bit.
- R10: Addresses 5 to 7 read 0. Unused bits of addresses 0 to 4 read 0, whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| alarm_in | input | 5 | Raw fault inputs, index 0 thermal to 4 reference |
| pad_out | output | 1 | Drive value toward the pad |
| pad_oe | output | 1 | Pad output enable |

## Verification
The hardest case to reach from the ports is a fault that is selected through one register half, arrives while the output is ON, and is then removed again. Only this sequence can show that a shutdown is latched rather than simply following the fault. The stimulus sweeps all 32 select masks against all 32 fault patterns. In every pass it enables the output, raises the pattern, and waits out the synchronizer delay. Whenever the pattern hits the mask, it then tries a re-enable while the fault is still present, drops the fault, and confirms that the output stays OFF until a fresh enable write.

// File: rtl/pa_drain_pkg.sv
package pa_drain_pkg;

    localparam int NUM_ALARMS  = 5;
    localparam int SRC_A_BITS  = 3;
    localparam int ADDR_W      = 3;
    localparam int DATA_W      = 8;
    localparam int SYNC_STAGES = 2;

    localparam int CTRL_ADDR  = 0;
    localparam int STAT_ADDR  = 1;
    localparam int SRCA_ADDR  = 2;
    localparam int SRCB_ADDR  = 3;
    localparam int CFG_ADDR   = 4;

    typedef struct packed {
        logic od;   // open-drain drive
        logic inv;  // inverted polarity
    } pad_cfg_t;

    typedef struct packed {
        logic drive;
        logic oe;
    } pad_drv_t;

    function automatic pad_drv_t map_pad(input logic on, input pad_cfg_t cfg);
        pad_drv_t r;
        logic lvl;
        lvl = on ^ cfg.inv;
        if (cfg.od) begin
            r.drive = 1'b0;
            r.oe    = ~lvl;
        end else begin
            r.drive = lvl;
            r.oe    = 1'b1;
        end
        return r;
    endfunction

endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[g] <= '0;
                    else     stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/drain_regs.sv
module drain_regs
    import pa_drain_pkg::*;
#(
    parameter int NA  = NUM_ALARMS,
    parameter int NSA = SRC_A_BITS,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NA-1:0] alarm_s,
    output logic [DW-1:0] rdata,
    output logic          on,
    output pad_cfg_t      cfg
);
    localparam int NSB = NA - NSA;

    logic          en_q;
    logic [NA-1:0] sel_q;
    pad_cfg_t      cfg_q;
    logic          trip;
    logic          wr_ctrl, wr_srca, wr_srcb, wr_cfg;

    assign wr_ctrl = we && (addr == AW'(CTRL_ADDR));
    assign wr_srca = we && (addr == AW'(SRCA_ADDR));
    assign wr_srcb = we && (addr == AW'(SRCB_ADDR));
    assign wr_cfg  = we && (addr == AW'(CFG_ADDR));
    assign trip    = |(alarm_s & sel_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sel_q <= '0;
            cfg_q <= '0;
        end else begin
            if (trip)         en_q <= 1'b0;
            else if (wr_ctrl) en_q <= wdata[0];
            if (wr_srca) sel_q[NSA-1:0]  <= wdata[NSA-1:0];
            if (wr_srcb) sel_q[NA-1:NSA] <= wdata[NSB-1:0];
            if (wr_cfg)  cfg_q <= pad_cfg_t'(wdata[1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            AW'(CTRL_ADDR): rdata[0]       = en_q;
            AW'(STAT_ADDR): rdata[0]       = en_q;
            AW'(SRCA_ADDR): rdata[NSA-1:0] = sel_q[NSA-1:0];
            AW'(SRCB_ADDR): rdata[NSB-1:0] = sel_q[NA-1:NSA];
            AW'(CFG_ADDR):  rdata[1:0]     = cfg_q;
            default:        rdata          = '0;
        endcase
    end

    assign on  = en_q;
    assign cfg = cfg_q;

    // R1
    reset_off_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !en_q);
    // R4
    trip_clears_chk: assert property (@(posedge clk) disable iff (rst)
        trip |=> !en_q);
    // R6
    rise_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(en_q) |-> $past(wr_ctrl && wdata[0]));
    // R9
    cfg_keeps_state_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_cfg && !wr_ctrl && !trip) |=> $stable(en_q));
endmodule

// File: rtl/pad_map.sv
module pad_map
    import pa_drain_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     on,
    input  pad_cfg_t cfg,
    output logic     pad_out,
    output logic     pad_oe
);
    pad_drv_t drv;

    assign drv     = map_pad(on, cfg);
    assign pad_out = drv.drive;
    assign pad_oe  = drv.oe;

    // R7
    pol_normal_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.od && !cfg.inv) |-> (pad_out == on));
    // R7
    pol_invert_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg.od && cfg.inv) |-> (pad_out != on));
    // R8
    od_low_only_chk: assert property (@(posedge clk) disable iff (rst)
        cfg.od |-> (!pad_out && (pad_oe == (on == cfg.inv))));
endmodule

// File: rtl/pa_drain_ctl.sv
module pa_drain_ctl
    import pa_drain_pkg::*;
#(
    parameter int NA  = NUM_ALARMS,
    parameter int NSA = SRC_A_BITS,
    parameter int AW  = ADDR_W,
    parameter int DW  = DATA_W,
    parameter int NSYNC = SYNC_STAGES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic [NA-1:0] alarm_in,
    output logic          pad_out,
    output logic          pad_oe
);
    logic [NA-1:0] alarm_s;
    logic          on;
    pad_cfg_t      cfg;

    alarm_sync #(.W(NA), .STAGES(NSYNC)) u_sync (
        .clk(clk), .rst(rst), .din(alarm_in), .dout(alarm_s)
    );

    drain_regs #(.NA(NA), .NSA(NSA), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .alarm_s(alarm_s), .rdata(reg_rdata),
        .on(on), .cfg(cfg)
    );

    pad_map u_pad (
        .clk(clk), .rst(rst), .on(on), .cfg(cfg),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );
endmodule

// File: tb/sim_pa_drain_ctl.sv
`timescale 1ns/1ps
module sim_pa_drain_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [4:0] alarm_in = '0;
    logic       pad_out, pad_oe;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #2.5 clk = ~clk;

    pa_drain_ctl u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alarm_in(alarm_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 3'(a);
        #0.5;
        v = int'(reg_rdata);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(1, v); chk("R1 status", v, 0);
        rd(0, v); chk("R1 enable", v, 0);
        chk("R1 pad_out", int'(pad_out), 0);
        chk("R1 pad_oe", int'(pad_oe), 1);

        // R10 reserved addresses and bits
        for (int a = 5; a < 8; a++) begin
            wr(a, 8'hFF);
            rd(a, v); chk("R10 reserved addr", v, 0);
        end
        wr(4, 8'hFF); rd(4, v); chk("R10 cfg bits", v, 3);
        wr(2, 8'hFF); rd(2, v); chk("R10 srcA bits", v, 7);
        wr(3, 8'hFF); rd(3, v); chk("R10 srcB bits", v, 3);
        wr(0, 8'hFF); rd(0, v); chk("R10 ctrl bits", v, 1);
        wr(4, 0); wr(2, 0); wr(3, 0); wr(0, 0);
        rd(1, v); chk("R2 off after write 0", v, 0);

        // R2..R6 exhaustive mask x fault sweep
        for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 32; p++) begin
                bit hit;
                hit = ((m & p) != 0);
                alarm_in = '0;
                settle();
                wr(2, m & 7);
                wr(3, (m >> 3) & 3);
                wr(0, 1);
                rd(1, v); chk("R2 on after enable", v, 1);
                rd(0, v); chk("R3 ctrl readback", v, 1);
                alarm_in = 5'(p);
                @(negedge clk); @(negedge clk);
                rd(1, v); chk("R4 still on before sync", v, 1);
                @(negedge clk);
                rd(1, v);
                if (hit) chk("R4 selected fault trips", v, 0);
                else     chk("R5 unselected fault ignored", v, 1);
                chk(hit ? "R4 pad off" : "R5 pad on", int'(pad_out), hit ? 0 : 1);
                if (hit) begin
                    wr(0, 1);
                    rd(1, v); chk("R6 enable ignored during fault", v, 0);
                    alarm_in = '0;
                    settle();
                    rd(1, v); chk("R6 sticky after clear", v, 0);
                    wr(0, 1);
                    rd(1, v); chk("R6 re-enable", v, 1);
                end
                wr(0, 0);
                rd(1, v); chk("R2 disable", v, 0);
            end
        end
        alarm_in = '0;
        wr(2, 0); wr(3, 0);
        settle();

        // R7/R8/R9 pad mapping sweep
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 4; c++) begin
                int inv, od, lvl;
                inv = c & 1; od = (c >> 1) & 1;
                lvl = s ^ inv;
                wr(0, s);
                wr(4, c);
                rd(1, v); chk("R9 status unchanged by cfg", v, s);
                chk(od ? "R8 od drive" : "R7 pp level", int'(pad_out), od ? 0 : lvl);
                chk(od ? "R8 od enable" : "R8 pp enable", int'(pad_oe), od ? (1 - lvl) : 1);
                wr(4, 0);
                rd(1, v); chk("R9 status after cfg restore", v, s);
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule